// File: doc/BRIEF.md
# Dual-Processor Mailbox with Claim Locks

This block lets two processors exchange short messages and coordinate ownership of shared resources. Side A is an application core and side B is a microcontroller. Each side reaches the block through its own simple register port: a request strobe, a write enable, a word address, write data and read data. Read data is combinational and valid in the same cycle as the request.

Four message elements each hold a 32-bit data word, a 32-bit command word and a pending flag. Elements 0 and 1 carry messages from A to B; elements 2 and 3 carry messages from B to A. The sender writes the data word and then the command word. The command write raises the element's flag, and the flag raises the receiver's interrupt when the receiver has enabled it. The receiver acknowledges by writing 1 to the flag's status bit. Thirty-two lock bits use read-to-claim semantics, so software can take a lock with one load and release it with one store.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, all data words, command words, flags, interrupt enables and locks are 0, and both interrupt outputs are low.
- R2: Element e has its data word at word address 2e and its command word at 2e+1. Both sides can read them. Only the sending side (A for elements 0 and 1, B for elements 2 and 3) can write them; a write from the other side has no effect.
- R3: A command write by the sender sets the element's flag, visible at status address 0x10 bit e from the next cycle. A data write leaves the flag unchanged.
- R4: The receiving side clears flag e by writing 1 to bit e at address 0x10. Bits written as 0 have no effect, and a write to 0x10 by the sending side has no effect. If a command write and a clear hit the same element in the same cycle, the flag stays set.
- R5: Each side has its own enable register at address 0x11, with bit e enabling element e. irq_b_o is high exactly when a flag of elements 0..1 is set and enabled by B. irq_a_o is high exactly when a flag of elements 2..3 is set and enabled by A. Each interrupt changes in the cycle after the write that changes its flag or enable.
- R6: Reading lock n at address 0x20+n returns 0 in bit 0 and takes the lock if the lock is free. If the lock is taken, the read returns 1 and changes nothing.
- R7: Writing a value whose bit 0 is 0 to a lock address releases that lock. Writing a value whose bit 0 is 1 has no effect.
- R8: When both sides access the same lock in the same cycle, only side A's access takes effect: a read by B returns 1, and a write by B is dropped.
- R9: Unmapped addresses read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_req_i | input | 1 | Side A access strobe |
| a_we_i | input | 1 | Side A write enable |
| a_addr_i | input | 8 | Side A word address |
| a_wdata_i | input | 32 | Side A write data |
| a_rdata_o | output | 32 | Side A read data, same cycle |
| b_req_i | input | 1 | Side B access strobe |
| b_we_i | input | 1 | Side B write enable |
| b_addr_i | input | 8 | Side B word address |
| b_wdata_i | input | 32 | Side B write data |
| b_rdata_o | output | 32 | Side B read data, same cycle |
| irq_a_o | output | 1 | Interrupt to side A (B-to-A messages pending) |
| irq_b_o | output | 1 | Interrupt to side B (A-to-B messages pending) |

## Verification
The hardest situations to reach are same-cycle collisions: both sides touching one lock, and a new command landing on an element in the same cycle its receiver acknowledges it. Directed steps drive both ports in one cycle to produce read/read, A-release/B-read and B-release/A-read lock collisions, as well as the set-versus-clear race. A long random phase then draws lock addresses from only four locks, so collisions keep recurring with every mix of reads and writes. A behavioural model predicts read data and both interrupts on every cycle.

// File: rtl/ipc_mailbox_pkg.sv
`timescale 1ns/1ps
package ipc_mailbox_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 8'h10;
  localparam logic [ADDR_W-1:0] IEN_ADDR  = 8'h11;
  localparam logic [ADDR_W-1:0] LOCK_BASE = 8'h20;

  typedef enum logic [2:0] {RG_DATA, RG_CMD, RG_STAT, RG_IEN, RG_LOCK, RG_NONE} reg_kind_e;

  typedef struct packed {
    reg_kind_e         kind;
    logic [ADDR_W-1:0] idx;
  } reg_sel_t;

  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                           input int unsigned n_elem,
                                           input int unsigned n_lock);
    reg_sel_t r;
    r.kind = RG_NONE;
    r.idx  = '0;
    if (32'(a) < 2 * n_elem) begin
      r.kind = a[0] ? RG_CMD : RG_DATA;
      r.idx  = {1'b0, a[ADDR_W-1:1]};
    end else if (a == STAT_ADDR) begin
      r.kind = RG_STAT;
    end else if (a == IEN_ADDR) begin
      r.kind = RG_IEN;
    end else if (a >= LOCK_BASE && 32'(a) < 32'(LOCK_BASE) + n_lock) begin
      r.kind = RG_LOCK;
      r.idx  = a - LOCK_BASE;
    end
    return r;
  endfunction
endpackage

// File: rtl/ipc_mbox_elem.sv
`timescale 1ns/1ps
module ipc_mbox_elem #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          data_we_i,
  input  logic          cmd_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          clr_i,
  output logic [DW-1:0] data_o,
  output logic [DW-1:0] cmd_o,
  output logic          flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      cmd_o  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (data_we_i) data_o <= wdata_i;
      if (cmd_we_i)  cmd_o  <= wdata_i;
      // a fresh command outranks a same-cycle acknowledge
      if (cmd_we_i)   flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ipc_mbox_locks.sv
`timescale 1ns/1ps
module ipc_mbox_locks #(
  parameter int unsigned N_LOCK = 32,
  parameter int unsigned IW     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_rd_i,
  input  logic              a_wr_i,
  input  logic [IW-1:0]     a_idx_i,
  input  logic              a_wbit_i,
  input  logic              b_rd_i,
  input  logic              b_wr_i,
  input  logic [IW-1:0]     b_idx_i,
  input  logic              b_wbit_i,
  output logic              a_rbit_o,
  output logic              b_rbit_o,
  output logic [N_LOCK-1:0] lock_o
);
  logic lock_q [N_LOCK];
  logic a_any, b_any, same;

  assign a_any = a_rd_i | a_wr_i;
  assign b_any = b_rd_i | b_wr_i;
  assign same  = a_any & b_any & (a_idx_i == b_idx_i);

  assign a_rbit_o = lock_q[a_idx_i];
  // side A owns a contested lock this cycle: B sees it as taken
  assign b_rbit_o = same | lock_q[b_idx_i];

  for (genvar i = 0; i < N_LOCK; i++) begin : g_lock
    logic a_hit, b_hit;
    assign a_hit = a_any & (a_idx_i == IW'(i));
    assign b_hit = b_any & (b_idx_i == IW'(i)) & ~same;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lock_q[i] <= 1'b0;
      end else if (a_hit) begin
        if (a_rd_i)         lock_q[i] <= 1'b1;
        else if (!a_wbit_i) lock_q[i] <= 1'b0;
      end else if (b_hit) begin
        if (b_rd_i)         lock_q[i] <= 1'b1;
        else if (!b_wbit_i) lock_q[i] <= 1'b0;
      end
    end

    assign lock_o[i] = lock_q[i];
  end
endmodule

// File: rtl/ipc_mailbox.sv
`timescale 1ns/1ps
module ipc_mailbox
  import ipc_mailbox_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned N_ELEM = 4,
  parameter int unsigned N_A2B  = 2,
  parameter int unsigned N_LOCK = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_req_i,
  input  logic              a_we_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DW-1:0]     a_wdata_i,
  output logic [DW-1:0]     a_rdata_o,
  input  logic              b_req_i,
  input  logic              b_we_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DW-1:0]     b_wdata_i,
  output logic [DW-1:0]     b_rdata_o,
  output logic              irq_a_o,
  output logic              irq_b_o
);
  localparam int unsigned LIW = (N_LOCK > 1) ? $clog2(N_LOCK) : 1;
  localparam int unsigned EIW = (N_ELEM > 1) ? $clog2(N_ELEM) : 1;
  localparam logic [N_ELEM-1:0] A2B_MASK = {N_ELEM{1'b1}} >> (N_ELEM - N_A2B);

  // per-side views, index 0 = side A, 1 = side B
  logic              s_req   [2];
  logic              s_we    [2];
  logic [ADDR_W-1:0] s_addr  [2];
  logic [DW-1:0]     s_wdata [2];
  logic [DW-1:0]     s_rdata [2];
  reg_sel_t          s_sel   [2];
  logic [N_ELEM-1:0] en_q    [2];
  logic              lk_rd   [2];
  logic              lk_wr   [2];
  logic              lk_rbit [2];

  logic [N_ELEM-1:0][DW-1:0] data_q, cmd_q;
  logic [N_ELEM-1:0]         flag_q;
  logic [N_LOCK-1:0]         lock_q;
  logic [N_ELEM-1:0]         en_b_q;

  assign s_req[0]   = a_req_i;
  assign s_we[0]    = a_we_i;
  assign s_addr[0]  = a_addr_i;
  assign s_wdata[0] = a_wdata_i;
  assign s_req[1]   = b_req_i;
  assign s_we[1]    = b_we_i;
  assign s_addr[1]  = b_addr_i;
  assign s_wdata[1] = b_wdata_i;
  assign a_rdata_o  = s_rdata[0];
  assign b_rdata_o  = s_rdata[1];
  assign en_b_q     = en_q[1];

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic wr;
    assign s_sel[s] = decode_addr(s_addr[s], N_ELEM, N_LOCK);
    assign wr       = s_req[s] & s_we[s];
    assign lk_rd[s] = s_req[s] & ~s_we[s] & (s_sel[s].kind == RG_LOCK);
    assign lk_wr[s] = wr & (s_sel[s].kind == RG_LOCK);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           en_q[s] <= '0;
      else if (wr && s_sel[s].kind == RG_IEN) en_q[s] <= s_wdata[s][N_ELEM-1:0];
    end

    always_comb begin
      s_rdata[s] = '0;
      unique case (s_sel[s].kind)
        RG_DATA: s_rdata[s] = data_q[s_sel[s].idx[EIW-1:0]];
        RG_CMD:  s_rdata[s] = cmd_q[s_sel[s].idx[EIW-1:0]];
        RG_STAT: s_rdata[s][N_ELEM-1:0] = flag_q;
        RG_IEN:  s_rdata[s][N_ELEM-1:0] = en_q[s];
        RG_LOCK: s_rdata[s][0] = lk_rbit[s];
        default: s_rdata[s] = '0;
      endcase
    end
  end

  for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
    localparam int unsigned SND = (e < N_A2B) ? 0 : 1;
    localparam int unsigned RCV = 1 - SND;
    logic snd_wr, data_we, cmd_we, clr;

    assign snd_wr  = s_req[SND] & s_we[SND] & (s_sel[SND].idx == ADDR_W'(e));
    assign data_we = snd_wr & (s_sel[SND].kind == RG_DATA);
    assign cmd_we  = snd_wr & (s_sel[SND].kind == RG_CMD);
    assign clr     = s_req[RCV] & s_we[RCV] & (s_sel[RCV].kind == RG_STAT) & s_wdata[RCV][e];

    ipc_mbox_elem #(.DW(DW)) u_elem (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .data_we_i(data_we),
      .cmd_we_i (cmd_we),
      .wdata_i  (s_wdata[SND]),
      .clr_i    (clr),
      .data_o   (data_q[e]),
      .cmd_o    (cmd_q[e]),
      .flag_o   (flag_q[e])
    );
  end

  ipc_mbox_locks #(.N_LOCK(N_LOCK), .IW(LIW)) u_locks (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .a_rd_i  (lk_rd[0]),
    .a_wr_i  (lk_wr[0]),
    .a_idx_i (s_sel[0].idx[LIW-1:0]),
    .a_wbit_i(s_wdata[0][0]),
    .b_rd_i  (lk_rd[1]),
    .b_wr_i  (lk_wr[1]),
    .b_idx_i (s_sel[1].idx[LIW-1:0]),
    .b_wbit_i(s_wdata[1][0]),
    .a_rbit_o(lk_rbit[0]),
    .b_rbit_o(lk_rbit[1]),
    .lock_o  (lock_q)
  );

  assign irq_b_o = |(flag_q & en_q[1] & A2B_MASK);
  assign irq_a_o = |(flag_q & en_q[0] & ~A2B_MASK);
endmodule

// File: rtl/ipc_mailbox_chk.sv
`timescale 1ns/1ps
module ipc_mailbox_chk
  import ipc_mailbox_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned N_ELEM = 4,
  parameter int unsigned N_LOCK = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              a_req_i,
  input logic              a_we_i,
  input logic [ADDR_W-1:0] a_addr_i,
  input logic [DW-1:0]     a_wdata_i,
  input logic [DW-1:0]     a_rdata_o,
  input logic              b_req_i,
  input logic              b_we_i,
  input logic [ADDR_W-1:0] b_addr_i,
  input logic [DW-1:0]     b_rdata_o,
  input logic              irq_a_o,
  input logic              irq_b_o,
  input logic [N_ELEM-1:0] flag_q,
  input logic [N_ELEM-1:0] en_b_q,
  input logic [N_LOCK-1:0] lock_q
);
  logic a_rd_l0, a_lock, b_en_wr;
  assign a_rd_l0 = a_req_i && !a_we_i && a_addr_i == LOCK_BASE;
  assign a_lock  = a_addr_i >= LOCK_BASE && 32'(a_addr_i) < 32'(LOCK_BASE) + N_LOCK;
  assign b_en_wr = b_req_i && b_we_i && b_addr_i == IEN_ADDR;

  AST_LOCK_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_rd_l0 && !lock_q[0] |-> a_rdata_o == '0 ##1 lock_q[0]); // R6
  AST_LOCK_TAKEN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_rd_l0 && lock_q[0] |-> a_rdata_o == DW'(1)); // R6
  AST_LOCK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_req_i && a_we_i && a_addr_i == LOCK_BASE && !a_wdata_i[0] |=> !lock_q[0]); // R7
  AST_LOCK_A_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_req_i && b_req_i && !b_we_i && a_lock && a_addr_i == b_addr_i |-> b_rdata_o == DW'(1)); // R8
  AST_CMD_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_req_i && a_we_i && a_addr_i == 8'h01 |=> flag_q[0]); // R3
  AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_req_i && a_we_i && a_addr_i == 8'h01 && en_b_q[0] && !b_en_wr |=> irq_b_o); // R5
  AST_IRQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q == '0 |-> !irq_a_o && !irq_b_o); // R5
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_req_i && !a_we_i && a_addr_i == 8'hFF |-> a_rdata_o == '0); // R9
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.DW(DW), .N_ELEM(N_ELEM), .N_LOCK(N_LOCK)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .a_req_i  (a_req_i),
  .a_we_i   (a_we_i),
  .a_addr_i (a_addr_i),
  .a_wdata_i(a_wdata_i),
  .a_rdata_o(a_rdata_o),
  .b_req_i  (b_req_i),
  .b_we_i   (b_we_i),
  .b_addr_i (b_addr_i),
  .b_rdata_o(b_rdata_o),
  .irq_a_o  (irq_a_o),
  .irq_b_o  (irq_b_o),
  .flag_q   (flag_q),
  .en_b_q   (en_b_q),
  .lock_q   (lock_q)
);

// File: tb/ipc_mailbox_test.sv
`timescale 1ns/1ps
module ipc_mailbox_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_req = 0, a_we = 0, b_req = 0, b_we = 0;
  logic [7:0]  a_addr = 0, b_addr = 0;
  logic [31:0] a_wd = 0, b_wd = 0;
  logic [31:0] a_rd, b_rd;
  logic        irq_a, irq_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] m_data [4];
  logic [31:0] m_cmd  [4];
  logic [3:0]  m_flag, m_ena, m_enb;
  logic [31:0] m_lock;

  always #2.5 clk = ~clk;

  ipc_mailbox uut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_req_i(a_req), .a_we_i(a_we), .a_addr_i(a_addr), .a_wdata_i(a_wd), .a_rdata_o(a_rd),
    .b_req_i(b_req), .b_we_i(b_we), .b_addr_i(b_addr), .b_wdata_i(b_wd), .b_rdata_o(b_rd),
    .irq_a_o(irq_a), .irq_b_o(irq_b)
  );

  function automatic bit is_lock(logic [7:0] ad);
    return ad >= 8'h20 && ad < 8'h40;
  endfunction

  function automatic logic [31:0] pred_rd(bit side_b, logic [7:0] ad, bit oreq, logic [7:0] oad);
    if (ad < 8'h08) return ad[0] ? m_cmd[ad[2:1]] : m_data[ad[2:1]];
    if (ad == 8'h10) return {28'd0, m_flag};
    if (ad == 8'h11) return {28'd0, side_b ? m_enb : m_ena};
    if (is_lock(ad)) begin
      if (side_b && oreq && oad == ad) return 32'd1;
      return {31'd0, m_lock[ad[4:0]]};
    end
    return 32'd0;
  endfunction

  function automatic string tag_of(bit side_b, logic [7:0] ad);
    if (ad < 8'h08) return "R2";
    if (ad == 8'h10) return "R3";
    if (ad == 8'h11) return "R5";
    if (is_lock(ad)) return (side_b && a_req && a_addr == ad) ? "R8" : "R6";
    return "R9";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update();
    logic [3:0] clr = 4'd0, set = 4'd0;
    bit a_hit, b_hit;
    if (a_req && a_we) begin
      if (a_addr < 8'h04) begin
        if (a_addr[0]) begin m_cmd[a_addr[2:1]] = a_wd; set[a_addr[2:1]] = 1'b1; end
        else m_data[a_addr[2:1]] = a_wd;
      end
      if (a_addr == 8'h10) clr = clr | (a_wd[3:0] & 4'b1100);
      if (a_addr == 8'h11) m_ena = a_wd[3:0];
    end
    if (b_req && b_we) begin
      if (b_addr >= 8'h04 && b_addr < 8'h08) begin
        if (b_addr[0]) begin m_cmd[b_addr[2:1]] = b_wd; set[b_addr[2:1]] = 1'b1; end
        else m_data[b_addr[2:1]] = b_wd;
      end
      if (b_addr == 8'h10) clr = clr | (b_wd[3:0] & 4'b0011);
      if (b_addr == 8'h11) m_enb = b_wd[3:0];
    end
    m_flag = (m_flag & ~clr) | set;
    a_hit = a_req && is_lock(a_addr);
    b_hit = b_req && is_lock(b_addr) && !(a_hit && a_addr == b_addr);
    if (a_hit) begin
      if (!a_we) m_lock[a_addr[4:0]] = 1'b1;
      else if (!a_wd[0]) m_lock[a_addr[4:0]] = 1'b0;
    end
    if (b_hit) begin
      if (!b_we) m_lock[b_addr[4:0]] = 1'b1;
      else if (!b_wd[0]) m_lock[b_addr[4:0]] = 1'b0;
    end
  endtask

  // one clock: drive after negedge, compare before posedge, update model at posedge
  task automatic step(string tag,
                      logic ar, logic aw, logic [7:0] aa, logic [31:0] ad,
                      logic br, logic bw, logic [7:0] ba, logic [31:0] bd);
    a_req = ar; a_we = aw; a_addr = aa; a_wd = ad;
    b_req = br; b_we = bw; b_addr = ba; b_wd = bd;
    #1;
    check(tag == "" ? "R5" : tag, {31'd0, irq_b}, {31'd0, |(m_flag & m_enb & 4'b0011)});
    check(tag == "" ? "R5" : tag, {31'd0, irq_a}, {31'd0, |(m_flag & m_ena & 4'b1100)});
    if (ar && !aw) check(tag == "" ? tag_of(0, aa) : tag, a_rd, pred_rd(0, aa, br, ba));
    if (br && !bw) check(tag == "" ? tag_of(1, ba) : tag, b_rd, pred_rd(1, ba, ar, aa));
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic rd_a(string tag, logic [7:0] aa); step(tag, 1, 0, aa, 0, 0, 0, 0, 0); endtask
  task automatic rd_b(string tag, logic [7:0] ba); step(tag, 0, 0, 0, 0, 1, 0, ba, 0); endtask
  task automatic wr_a(string tag, logic [7:0] aa, logic [31:0] d); step(tag, 1, 1, aa, d, 0, 0, 0, 0); endtask
  task automatic wr_b(string tag, logic [7:0] ba, logic [31:0] d); step(tag, 0, 0, 0, 0, 1, 1, ba, d); endtask

  function automatic logic [7:0] pick_addr();
    int unsigned r = $urandom_range(0, 15);
    if (r < 8) return 8'(r);
    if (r == 8) return 8'h10;
    if (r == 9) return 8'h11;
    if (r == 10) return 8'hFF;
    return 8'h20 + 8'($urandom_range(0, 3));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_data[i] = 0; m_cmd[i] = 0; end
    m_flag = 0; m_ena = 0; m_enb = 0; m_lock = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state seen from both ports
    step("R1", 1, 0, 8'h00, 0, 1, 0, 8'h07, 0);
    step("R1", 1, 0, 8'h10, 0, 1, 0, 8'h10, 0);
    step("R1", 1, 0, 8'h11, 0, 1, 0, 8'h11, 0);
    step("R1", 1, 0, 8'h3F, 0, 1, 0, 8'h21, 0);

    // R2/R3: data write leaves flag clear, command write raises it
    wr_a("R2", 8'h00, 32'hDEADBEEF);
    rd_b("R2", 8'h00);
    rd_b("R3", 8'h10);
    wr_a("R3", 8'h01, 32'h0000_0011);
    rd_b("R3", 8'h10);
    rd_b("R2", 8'h01);
    // R5: interrupt follows enable
    wr_b("R5", 8'h11, 32'h1);
    rd_a("R5", 8'h10);
    // R4: sender write and zero bits ignored, receiver W1C clears
    wr_a("R4", 8'h10, 32'hF);
    rd_b("R4", 8'h10);
    wr_b("R4", 8'h10, 32'h0);
    rd_b("R4", 8'h10);
    wr_b("R4", 8'h10, 32'h1);
    rd_b("R4", 8'h10);
    // R2: non-sender write ignored
    wr_b("R2", 8'h00, 32'h5);
    rd_a("R2", 8'h00);
    wr_a("R2", 8'h05, 32'h7);
    rd_b("R2", 8'h05);
    // B-to-A message, interrupt to A
    wr_b("R2", 8'h04, 32'hCAFE0004);
    wr_b("R3", 8'h05, 32'h22);
    wr_a("R5", 8'h11, 32'h4);
    rd_a("R2", 8'h04);
    // R4: set and clear in one cycle, set wins
    step("R4", 1, 1, 8'h10, 32'h4, 1, 1, 8'h05, 32'h23);
    rd_a("R4", 8'h10);
    wr_a("R4", 8'h10, 32'h4);
    rd_a("R4", 8'h10);

    // R6: claim then taken
    rd_a("R6", 8'h20);
    rd_a("R6", 8'h20);
    rd_b("R6", 8'h20);
    // R7: write 1 ignored, write 0 releases
    wr_b("R7", 8'h20, 32'h1);
    rd_a("R7", 8'h20);
    wr_b("R7", 8'h20, 32'hFFFF_FFFE);
    rd_b("R7", 8'h20);
    rd_a("R7", 8'h20);
    // R8: contested lock
    step("R8", 1, 0, 8'h21, 0, 1, 0, 8'h21, 0);
    step("R8", 1, 1, 8'h21, 0, 1, 0, 8'h21, 0);
    rd_b("R8", 8'h21);
    wr_b("R7", 8'h21, 0);
    step("R8", 1, 0, 8'h20, 0, 1, 1, 8'h20, 0);
    rd_b("R8", 8'h20);
    // R9: unmapped
    wr_a("R9", 8'hFF, 32'h1234);
    rd_a("R9", 8'hFF);
    rd_b("R9", 8'h12);

    // random phase with heavy lock contention
    for (int n = 0; n < 4000; n++) begin
      step("", 1'($urandom), 1'($urandom), pick_addr(), $urandom,
               1'($urandom), 1'($urandom), pick_addr(), $urandom);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule